// File: doc/BRIEF.md
# Asynchronous SRAM Write Strobe Sequencer

This block sits between a clocked host and one port of an external asynchronous static RAM. The host hands it one word at a time (address, data, an output-enable choice and a strobe mode). The block then plays out a write cycle on the memory pins, cycle by cycle, with every timing interval given as a whole number of clocks. The address is set up ahead of the last strobe, the two strobes overlap for the required pulse width, and the data drivers turn on and off at the right moments. Recovery is then counted before the next cycle may start.

Two write styles are offered. With the read/write strobe in control, chip-enable falls together with the address and read/write is pulsed. With chip-enable in control, read/write falls first and chip-enable is pulsed. If output-enable is held low during a read/write-controlled write, the memory is driving the bus when the pulse starts. In that case the block waits for the memory's turn-off time before enabling its own drivers, and it widens the pulse so that the full data setup still fits.

Top module: `sram_wr_seq`

## Requirements
- R1: During reset and whenever idle, both strobes and the output-enable pin are high, the data drive enable is low, and busy and done are low.
- R2: Request, address, data, output-enable choice and mode are sampled only in an idle cycle with `req` high. Changes to them, including `req` pulses, while busy have no effect on the cycle under way.
- R3: Counting cycle 0 as the first clock after the sampling edge, address and the leading strobe (chip-enable when `wr_mode`=0, read/write when `wr_mode`=1) go valid/low in cycle 0. The controlling strobe falls at cycle T_AS.
- R4: The memory address never changes while both strobes are low.
- R5: Both strobes stay low together for max(T_WP, T_WZ+T_DW) cycles when `wr_mode`=0 and `oe_low`=1, and for max(T_WP, T_DW) cycles otherwise.
- R6: Data drive enable rises T_WZ cycles into the overlap when `wr_mode`=0 and `oe_low`=1, and at the first overlap cycle otherwise. It stays high through the overlap and for T_DH cycles after the strobes rise.
- R7: Both strobes rise in the same cycle. Busy stays high from cycle 0 through max(T_WR, T_DH) recovery cycles. In the following cycle busy is low and done is high for exactly one clock.
- R8: A request present during the done cycle is accepted at the next edge, so writes may run back to back.
- R9: The data drive enable is never high while chip-enable and output-enable are low and read/write is high.
- R10: The output-enable pin is low during a busy cycle exactly when the sampled `oe_low` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Write request, sampled when idle |
| wr_mode | input | 1 | 0: read/write strobe controls the write, 1: chip-enable controls it |
| oe_low | input | 1 | Hold the memory output-enable low during the write |
| addr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data |
| busy | output | 1 | A write cycle is in progress |
| done | output | 1 | One-clock pulse after recovery ends |
| sram_ce_n | output | 1 | Memory chip-enable, active low |
| sram_rw_n | output | 1 | Memory read/write, low for write |
| sram_oe_n | output | 1 | Memory output-enable, active low |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_out | output | DATA_W | Data toward the memory bus |
| sram_dq_oe | output | 1 | Enable for the data bus drivers |

## Verification
Every pin of a write is due at a fixed offset from the edge that samples the request. The address phase occupies cycles 0 to T_AS-1, the overlap the next P cycles, recovery the next R cycles, and done falls in cycle T_AS+P+R. The driver task restates P, R and the drive-enable start from the requirements and queues one expected pin vector per cycle from cycle 0 onward. The monitor pops one vector at each falling clock edge, half a period after the register update, so every check lands on the cycle in which a value is due. Back-to-back and mid-cycle input changes keep the same per-cycle queue, so any shift of a phase by one cycle shows up as a miscompare.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_PULSE = 2'd2,
    ST_REC   = 2'd3
  } wr_state_e;

  localparam logic MODE_RW_CTRL = 1'b0;
  localparam logic MODE_CE_CTRL = 1'b1;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Memory outputs are live at the pulse start only for a read/write-controlled
  // write with output-enable low.
  function automatic bit bus_contended(input logic mode, input logic oe_low);
    return (mode == MODE_RW_CTRL) && oe_low;
  endfunction

  function automatic int unsigned overlap_cycles(input int unsigned wp, input int unsigned dw,
                                                 input int unsigned wz, input logic mode,
                                                 input logic oe_low);
    if (bus_contended(mode, oe_low)) return max2(max2(wp, wz + dw), 1);
    return max2(max2(wp, dw), 1);
  endfunction

  function automatic int unsigned drive_delay(input int unsigned wz, input logic mode,
                                              input logic oe_low);
    return bus_contended(mode, oe_low) ? wz : 0;
  endfunction

  function automatic int unsigned recovery_cycles(input int unsigned wr, input int unsigned dh);
    return max2(max2(wr, dh), 1);
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] elapsed
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                    elapsed <= '0;
    else if (restart)           elapsed <= '0;
    else if (elapsed != CNT_MAX) elapsed <= elapsed + 1'b1;
  end

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned T_AS   = 2,
  parameter int unsigned T_WP   = 3,
  parameter int unsigned T_DW   = 2,
  parameter int unsigned T_DH   = 1,
  parameter int unsigned T_WR   = 2,
  parameter int unsigned T_WZ   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr_mode,
  input  logic              oe_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  elapsed,
  output logic              restart,
  output wr_state_e         state,
  output logic              lat_mode,
  output logic              lat_oe_low,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic [CNT_W-1:0]  pulse_len,
  output logic [CNT_W-1:0]  drive_wait,
  output logic              done_q
);

  localparam logic [CNT_W-1:0] AS_LEN  = CNT_W'(max2(T_AS, 1));
  localparam logic [CNT_W-1:0] REC_LEN = CNT_W'(recovery_cycles(T_WR, T_DH));

  logic [CNT_W-1:0] cur_len;
  logic             phase_end;
  logic             accept;
  wr_state_e        state_nx;

  assign accept = (state == ST_IDLE) && req;

  always_comb begin
    unique case (state)
      ST_ADDR:  cur_len = AS_LEN;
      ST_PULSE: cur_len = pulse_len;
      ST_REC:   cur_len = REC_LEN;
      default:  cur_len = '0;
    endcase
  end

  assign phase_end = (state != ST_IDLE) && (elapsed == cur_len - 1'b1);
  assign restart   = phase_end || (state == ST_IDLE);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept)    state_nx = ST_ADDR;
      ST_ADDR:  if (phase_end) state_nx = ST_PULSE;
      ST_PULSE: if (phase_end) state_nx = ST_REC;
      ST_REC:   if (phase_end) state_nx = ST_IDLE;
      default:                 state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      lat_mode   <= MODE_RW_CTRL;
      lat_oe_low <= 1'b0;
      lat_addr   <= '0;
      lat_wdata  <= '0;
      pulse_len  <= '0;
      drive_wait <= '0;
      done_q     <= 1'b0;
    end else begin
      state  <= state_nx;
      done_q <= (state == ST_REC) && phase_end;
      if (accept) begin
        lat_mode   <= wr_mode;
        lat_oe_low <= oe_low;
        lat_addr   <= addr;
        lat_wdata  <= wdata;
        pulse_len  <= CNT_W'(overlap_cycles(T_WP, T_DW, T_WZ, wr_mode, oe_low));
        drive_wait <= CNT_W'(drive_delay(T_WZ, wr_mode, oe_low));
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (state == ST_IDLE));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(lat_addr) && $stable(lat_wdata) && $stable(lat_mode));

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned T_DH  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_state_e        state,
  input  logic             lat_mode,
  input  logic             lat_oe_low,
  input  logic [CNT_W-1:0] elapsed,
  input  logic [CNT_W-1:0] drive_wait,
  input  logic [CNT_W-1:0] pulse_len,
  output logic             ce_n,
  output logic             rw_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic             busy
);

  localparam logic [CNT_W-1:0] DH_LEN = CNT_W'(T_DH);

  logic in_addr, in_pulse, in_rec;
  logic lead_low, ctrl_low;
  logic both_low, mem_drives;
  logic [CNT_W-1:0] ovl_run;

  assign in_addr  = (state == ST_ADDR);
  assign in_pulse = (state == ST_PULSE);
  assign in_rec   = (state == ST_REC);
  assign busy     = (state != ST_IDLE);

  assign lead_low = in_addr || in_pulse;
  assign ctrl_low = in_pulse;

  assign ce_n  = (lat_mode == MODE_RW_CTRL) ? !lead_low : !ctrl_low;
  assign rw_n  = (lat_mode == MODE_RW_CTRL) ? !ctrl_low : !lead_low;
  assign oe_n  = !(busy && lat_oe_low);
  assign dq_oe = (in_pulse && (elapsed >= drive_wait)) || (in_rec && (elapsed < DH_LEN));

  // Observation wires for the checks below.
  assign both_low   = !ce_n && !rw_n;
  assign mem_drives = !ce_n && rw_n && !oe_n;

  always_ff @(posedge clk) begin
    if (rst)           ovl_run <= '0;
    else if (both_low) ovl_run <= ovl_run + 1'b1;
    else               ovl_run <= '0;
  end

  // R9
  bus_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe && mem_drives));

  // R1
  idle_safe_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ce_n && rw_n && oe_n && !dq_oe));

  // R5
  overlap_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(both_low) |-> (ovl_run >= pulse_len));

  // R7
  strobe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ce_n) |-> rw_n);

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_AS   = 2,
  parameter int unsigned T_WP   = 3,
  parameter int unsigned T_DW   = 2,
  parameter int unsigned T_DH   = 1,
  parameter int unsigned T_WR   = 2,
  parameter int unsigned T_WZ   = 2,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr_mode,
  input  logic              oe_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic              sram_ce_n,
  output logic              sram_rw_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe
);

  localparam int unsigned LONGEST = max2(max2(T_AS, overlap_cycles(T_WP, T_DW, T_WZ, 1'b0, 1'b1)),
                                         recovery_cycles(T_WR, T_DH));

  initial begin
    if (LONGEST >= (1 << CNT_W)) $error("CNT_W too small for the configured intervals");
  end

  logic [CNT_W-1:0] elapsed, pulse_len, drive_wait;
  logic             restart, lat_mode, lat_oe_low;
  wr_state_e        state;

  sram_wr_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .restart(restart), .elapsed(elapsed)
  );

  sram_wr_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .T_AS(T_AS), .T_WP(T_WP),
    .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR), .T_WZ(T_WZ)
  ) fsm_i (
    .clk(clk), .rst(rst), .req(req), .wr_mode(wr_mode), .oe_low(oe_low),
    .addr(addr), .wdata(wdata), .elapsed(elapsed), .restart(restart),
    .state(state), .lat_mode(lat_mode), .lat_oe_low(lat_oe_low),
    .lat_addr(sram_addr), .lat_wdata(sram_dq_out), .pulse_len(pulse_len),
    .drive_wait(drive_wait), .done_q(done)
  );

  sram_wr_pins #(.CNT_W(CNT_W), .T_DH(T_DH)) pins_i (
    .clk(clk), .rst(rst), .state(state), .lat_mode(lat_mode), .lat_oe_low(lat_oe_low),
    .elapsed(elapsed), .drive_wait(drive_wait), .pulse_len(pulse_len),
    .ce_n(sram_ce_n), .rw_n(sram_rw_n), .oe_n(sram_oe_n), .dq_oe(sram_dq_oe), .busy(busy)
  );

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !sram_rw_n) |-> $stable(sram_addr));

  // R10
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !sram_oe_n) |=> (sram_oe_n == !busy || !sram_oe_n));

endmodule

// File: tb/sram_wr_seq_tb.sv
module sram_wr_seq_tb_top;

  localparam int unsigned AW = 12, DW_ = 8;
  localparam int unsigned TAS = 2, TWP = 3, TDW = 2, TDH = 1, TWR = 2, TWZ = 2;

  typedef struct packed {
    logic ce_n, rw_n, oe_n, dq_oe, busy, done;
    logic [AW-1:0]  a;
    logic [DW_-1:0] d;
  } pinv_t;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, wr_mode = 1'b0, oe_low = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [DW_-1:0] wdata = '0;
  logic busy, done, sram_ce_n, sram_rw_n, sram_oe_n, sram_dq_oe;
  logic [AW-1:0]  sram_addr;
  logic [DW_-1:0] sram_dq_out;

  int checks = 0, fails = 0;
  bit finished = 0;
  pinv_t exp_q[$];
  string tag_q[$];
  logic [AW-1:0]  last_a = '0;
  logic [DW_-1:0] last_d = '0;

  always #4 clk = ~clk;

  sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW_), .T_AS(TAS), .T_WP(TWP), .T_DW(TDW),
                .T_DH(TDH), .T_WR(TWR), .T_WZ(TWZ), .CNT_W(6)) dut_i (
    .clk(clk), .rst(rst), .req(req), .wr_mode(wr_mode), .oe_low(oe_low),
    .addr(addr), .wdata(wdata), .busy(busy), .done(done), .sram_ce_n(sram_ce_n),
    .sram_rw_n(sram_rw_n), .sram_oe_n(sram_oe_n), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe)
  );

  function automatic pinv_t observed();
    return '{sram_ce_n, sram_rw_n, sram_oe_n, sram_dq_oe, busy, done, sram_addr, sram_dq_out};
  endfunction

  task automatic compare(input pinv_t got, input pinv_t exp, input string tg);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got ce=%b rw=%b oe=%b drv=%b busy=%b done=%b a=%h d=%h exp ce=%b rw=%b oe=%b drv=%b busy=%b done=%b a=%h d=%h",
               tg, got.ce_n, got.rw_n, got.oe_n, got.dq_oe, got.busy, got.done, got.a, got.d,
               exp.ce_n, exp.rw_n, exp.oe_n, exp.dq_oe, exp.busy, exp.done, exp.a, exp.d);
    end
  endtask

  // Monitor: one expected vector per falling edge.
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) compare(observed(), exp_q.pop_front(), tag_q.pop_front());
  end

  function automatic pinv_t idle_vec();
    return '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, last_a, last_d};
  endfunction

  // Caller is at a falling edge.
  task automatic idle_cycles(input int n, input string tg);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      exp_q.push_back(idle_vec()); tag_q.push_back(tg);
      @(negedge clk);
    end
  endtask

  // Caller is at a falling edge; returns at the falling edge of the done cycle.
  task automatic drive_write(input logic m, input logic oel, input logic [AW-1:0] a,
                             input logic [DW_-1:0] d, input bit scramble, input string tg);
    int p, w, r, len;
    req = 1'b1; wr_mode = m; oe_low = oel; addr = a; wdata = d;
    // Restated from R5, R6, R7.
    if (m == 1'b0 && oel) begin
      p = (TWZ + TDW > TWP) ? TWZ + TDW : TWP;
      w = TWZ;
    end else begin
      p = (TDW > TWP) ? TDW : TWP;
      w = 0;
    end
    r = (TDH > TWR) ? TDH : TWR;
    len = TAS + p + r;
    @(posedge clk); #1;
    req = 1'b0;
    last_a = a; last_d = d;
    for (int k = 0; k <= len; k++) begin
      pinv_t v;
      bit lead, ctrl;
      string ph;
      lead = (k < TAS + p);
      ctrl = (k >= TAS) && (k < TAS + p);
      v.ce_n  = m ? !ctrl : !lead;
      v.rw_n  = m ? !lead : !ctrl;
      v.oe_n  = !((k < len) && oel);
      v.dq_oe = ((k >= TAS + w) && (k < TAS + p)) || ((k >= TAS + p) && (k < TAS + p + TDH));
      v.busy  = (k < len);
      v.done  = (k == len);
      v.a = a; v.d = d;
      if (k < TAS)            ph = "R3 addr phase";
      else if (k < TAS + p)   ph = "R5 R6 R10 overlap";
      else if (k < len)       ph = "R6 R7 recovery";
      else                    ph = "R7 done";
      exp_q.push_back(v); tag_q.push_back({tg, " ", ph});
    end
    if (scramble) begin
      wr_mode = ~m; oe_low = ~oel; addr = ~a; wdata = ~d;
      repeat (2) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (len - 2) @(negedge clk);
    end else begin
      repeat (len + 1) @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(observed(), idle_vec(), "R1 reset");
    rst = 1'b0;
    idle_cycles(2, "R1 idle");
    drive_write(1'b0, 1'b1, 12'h3A5, 8'hC3, 0, "R9 rw-ctrl oe_low");
    idle_cycles(1, "R1 idle");
    drive_write(1'b0, 1'b0, 12'h0F0, 8'h5A, 0, "rw-ctrl oe_high");
    drive_write(1'b1, 1'b1, 12'hFFF, 8'hFF, 0, "R8 ce-ctrl oe_low back-to-back");
    drive_write(1'b1, 1'b0, 12'h001, 8'h01, 1, "R2 ce-ctrl scrambled");
    idle_cycles(2, "R1 R2 idle after ignored req");
    drive_write(1'b0, 1'b1, 12'h800, 8'h80, 1, "R2 rw-ctrl scrambled");
    idle_cycles(2, "R1 idle");
    wait (exp_q.size() == 0);
    @(posedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung run, exp completion");
    summary();
  end

endmodule